// File: doc/BRIEF.md
# Reference clock failover controller

This block picks one of two reference clocks, a primary and a backup, and passes it to a single clock output. A free-running system clock paces a loss detector for each reference. The detector counts system-clock windows in which no edge of that reference arrived. It raises a per-input bad flag and drops it again once the reference has run for several windows in a row. A small state machine moves the selection when the active input fails, or when a manual request arrives. The request can come in either direction. A programmable delay comes before each move, and a settle period follows it. A gating stage then hands the output from one reference to the other without glitches.

The state machine has three states. In RUN the selection is stable. A trigger moves RUN to DELAY. The trigger is a rising edge of the synchronized switch request, or, with automatic mode on, a bad active input. Either way the other input must be good. DELAY counts `SWITCH_DELAY` cycles and then moves to HAND, flipping the selection as it does so. If the target turns bad while counting, DELAY returns to RUN and leaves the selection alone. HAND counts `SETTLE` cycles while the gating stage completes the handover, then returns to RUN. A trigger seen in DELAY or HAND has no effect.

Top module: `refclk_failover`

## Requirements
- R1: After reset, `active_sel` is 0 (primary) and both bad flags are 0 until the first monitoring window of `WINDOW` system cycles has ended.
- R2: A bad flag is set at the end of a window of `WINDOW` system cycles in which no synchronized edge of that reference was seen. A reference that keeps toggling is never flagged.
- R3: A set bad flag clears only after `GOOD_WINDOWS` consecutive windows that each contained an edge. One window after a stopped reference restarts, its flag is still set.
- R4: With `auto_en` = 1, when the selected input is bad and the other is good, the state machine leaves RUN on the next edge. `active_sel` flips `SWITCH_DELAY` edges later. This happens in either direction.
- R5: A rising edge on the asynchronous `switch_req` toggles `active_sel` (0 = primary, 1 = backup). The new value appears on the `SWITCH_DELAY`+3rd system edge, counting the first edge that samples the request high. This works in both directions.
- R6: With `auto_en` = 0, a bad selected input causes no switchover.
- R7: The selection never moves to an input whose bad flag is set. When both flags are set, `active_sel` holds and both flags stay high.
- R8: A switch request that rises while a switchover is in DELAY or HAND is ignored. Each press causes at most one toggle.
- R9: At most one reference gate is open at any time. Once a handover has settled, `clk_out` carries the edges of the selected reference.
- R10: A handover away from a stopped reference completes. `clk_out` then follows the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock for monitoring and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pri | input | 1 | Primary reference clock |
| ref_bak | input | 1 | Backup reference clock |
| auto_en | input | 1 | 1 = automatic failover plus manual, 0 = manual only |
| switch_req | input | 1 | Asynchronous manual switch request; each rising edge toggles |
| clk_out | output | 1 | Gated, glitch-free selected reference |
| bad_pri | output | 1 | Primary reference detected as stopped |
| bad_bak | output | 1 | Backup reference detected as stopped |
| active_sel | output | 1 | Selected input: 0 primary, 1 backup |

## Verification
The hardest case to reach is a handover away from a reference that has already stopped. Its gate can no longer close on its own falling edge, so it has to be cleared from the control side. The bench gets there by halting the primary clock in manual-only mode until its flag rises, then turning automatic mode on. It then counts `clk_out` edges to confirm the backup took over. A second hard case is a request that lands inside DELAY. The bench reaches it with two short pulses placed four cycles apart, and the per-cycle model confirms that only one toggle follows.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DELAY = 2'd1,
        ST_HAND  = 2'd2
    } swap_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rcf_loss_monitor.sv
module rcf_loss_monitor #(
    parameter int WINDOW       = 16,
    parameter int GOOD_WINDOWS = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic ref_bad
);
    localparam int WW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam int GW = $clog2(GOOD_WINDOWS + 1);

    logic          tog_q;
    logic [2:0]    sync_q;
    logic [WW-1:0] win_q;
    logic [GW-1:0] good_q;
    logic          seen_q;
    logic          edge_now;
    logic          win_last;
    logic          got_edge;

    // toggles once per reference rising edge
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tog_q};
    end

    assign edge_now = sync_q[2] ^ sync_q[1];
    assign win_last = (win_q == WW'(WINDOW - 1));
    assign got_edge = seen_q | edge_now;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            seen_q  <= 1'b0;
            good_q  <= '0;
            ref_bad <= 1'b0;
        end else begin
            win_q  <= win_last ? '0 : win_q + 1'b1;
            seen_q <= win_last ? 1'b0 : got_edge;
            if (win_last) begin
                if (!got_edge) begin
                    ref_bad <= 1'b1;
                    good_q  <= '0;
                end else if (ref_bad) begin
                    if (good_q == GW'(GOOD_WINDOWS - 1)) begin
                        ref_bad <= 1'b0;
                        good_q  <= '0;
                    end else begin
                        good_q <= good_q + 1'b1;
                    end
                end
            end
        end
    end

    // R2: the flag may only rise at a window boundary
    assert_flag_at_window_end_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(ref_bad) |-> $past(win_last));

    // R3: the flag may only fall after a window that saw an edge
    assert_clear_needs_edges_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(ref_bad) |-> ($past(win_last) && $past(got_edge)));

endmodule

// File: rtl/rcf_select_fsm.sv
module rcf_select_fsm
    import rcf_pkg::*;
#(
    parameter int SWITCH_DELAY = 4,
    parameter int SETTLE       = 32
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic switch_req,
    input  logic bad_pri,
    input  logic bad_bak,
    output logic sel,
    output logic kill_pri,
    output logic kill_bak
);
    localparam int CMAX = max2(SWITCH_DELAY, SETTLE);
    localparam int CW   = $clog2(CMAX + 1);

    swap_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [2:0]    req_q;
    logic          req_rise;
    logic          bad_cur;
    logic          bad_oth;

    assign req_rise = req_q[1] & ~req_q[2];
    assign bad_cur  = sel ? bad_bak : bad_pri;
    assign bad_oth  = sel ? bad_pri : bad_bak;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (!bad_oth && (req_rise || (auto_en && bad_cur)))
                          state_d = ST_DELAY;
            ST_DELAY: if (bad_oth)
                          state_d = ST_RUN;
                      else if (cnt_q == CW'(SWITCH_DELAY - 1))
                          state_d = ST_HAND;
            ST_HAND:  if (cnt_q == CW'(SETTLE - 1))
                          state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            cnt_q    <= '0;
            sel      <= 1'b0;
            kill_pri <= 1'b0;
            kill_bak <= 1'b0;
        end else begin
            req_q    <= {req_q[1:0], switch_req};
            cnt_q    <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == ST_DELAY && state_d == ST_HAND)
                sel <= ~sel;
            kill_pri <= bad_pri & sel;
            kill_bak <= bad_bak & ~sel;
        end
    end

    // R7: never move onto a flagged input
    assert_no_move_to_bad_bak_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(sel) |-> !$past(bad_bak));
    assert_no_move_to_bad_pri_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(sel) |-> !$past(bad_pri));

    // R5: the selection only moves at the end of the delay
    assert_move_after_delay_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> ($past(state_q) == ST_DELAY && state_q == ST_HAND));

    // R8: no new switchover starts during the settle period
    assert_settle_blocks_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ($past(state_q) == ST_HAND) |-> (state_q != ST_DELAY));

endmodule

// File: rtl/rcf_glitchless_mux.sv
module rcf_glitchless_mux #(
    parameter int SRC = 2
) (
    input  logic           rst_n,
    input  logic [SRC-1:0] ref_clk,
    input  logic [SRC-1:0] want,
    input  logic [SRC-1:0] kill,
    output logic [SRC-1:0] gate,
    output logic           clk_out
);
    for (genvar i = 0; i < SRC; i++) begin : g_lane
        logic clr;
        logic s1_q, s2_q;
        logic others_open;

        assign clr         = ~rst_n | kill[i];
        assign others_open = |(gate & ~(SRC'(1) << i));

        // gate flops run on the falling edge of their own reference
        always_ff @(negedge ref_clk[i] or posedge clr) begin
            if (clr) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= want[i] & ~others_open;
                s2_q <= s1_q;
            end
        end

        assign gate[i] = s2_q;
    end

    assign clk_out = |(ref_clk & gate);

endmodule

// File: rtl/refclk_failover.sv
module refclk_failover #(
    parameter int WINDOW       = 16,
    parameter int GOOD_WINDOWS = 2,
    parameter int SWITCH_DELAY = 4,
    parameter int SETTLE       = 32
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic ref_pri,
    input  logic ref_bak,
    input  logic auto_en,
    input  logic switch_req,
    output logic clk_out,
    output logic bad_pri,
    output logic bad_bak,
    output logic active_sel
);
    logic       sel;
    logic       kill_pri, kill_bak;
    logic [1:0] gates;

    rcf_loss_monitor #(.WINDOW(WINDOW), .GOOD_WINDOWS(GOOD_WINDOWS)) u_mon_pri (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .ref_clk (ref_pri),
        .ref_bad (bad_pri)
    );

    rcf_loss_monitor #(.WINDOW(WINDOW), .GOOD_WINDOWS(GOOD_WINDOWS)) u_mon_bak (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .ref_clk (ref_bak),
        .ref_bad (bad_bak)
    );

    rcf_select_fsm #(.SWITCH_DELAY(SWITCH_DELAY), .SETTLE(SETTLE)) u_fsm (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .switch_req (switch_req),
        .bad_pri    (bad_pri),
        .bad_bak    (bad_bak),
        .sel        (sel),
        .kill_pri   (kill_pri),
        .kill_bak   (kill_bak)
    );

    rcf_glitchless_mux #(.SRC(2)) u_mux (
        .rst_n   (rst_n),
        .ref_clk ({ref_bak, ref_pri}),
        .want    ({sel, ~sel}),
        .kill    ({kill_bak, kill_pri}),
        .gate    (gates),
        .clk_out (clk_out)
    );

    assign active_sel = sel;

    // R9: the two gates are never open together
    assert_single_gate_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $onehot0(gates));

    // R6: in manual-only mode a bad flag alone never moves the selection
    assert_manual_only_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!auto_en && $past(!auto_en) && $past(!auto_en, 2) && $past(!auto_en, 3)
         && $past(!auto_en, 4) && $past(!auto_en, 5) && $past(!auto_en, 6)
         && $past(!auto_en, 7) && $past(!auto_en, 8) && $past(!auto_en, 9)
         && $past(!switch_req, 3) && $past(!switch_req, 4) && $past(!switch_req, 5)
         && $past(!switch_req, 6) && $past(!switch_req, 7) && $past(!switch_req, 8)
         && $past(!switch_req, 9) && SWITCH_DELAY <= 4)
        |-> $stable(sel));

endmodule

// File: tb/refclk_failover_bench.sv
module refclk_failover_bench;
    localparam int WINDOW = 16;
    localparam int GOODW  = 2;
    localparam int DLY    = 4;
    localparam int SETTLE = 32;

    logic sys_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pri = 1'b0;
    logic ref_bak = 1'b0;
    logic auto_en = 1'b1;
    logic switch_req = 1'b0;
    logic pri_on = 1'b1;
    logic bak_on = 1'b1;
    logic clk_out, bad_pri, bad_bak, active_sel;

    int n_chk = 0;
    int n_fail = 0;
    int out_edges = 0;

    refclk_failover #(.WINDOW(WINDOW), .GOOD_WINDOWS(GOODW),
                      .SWITCH_DELAY(DLY), .SETTLE(SETTLE)) u_refclk_failover (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .ref_pri    (ref_pri),
        .ref_bak    (ref_bak),
        .auto_en    (auto_en),
        .switch_req (switch_req),
        .clk_out    (clk_out),
        .bad_pri    (bad_pri),
        .bad_bak    (bad_bak),
        .active_sel (active_sel)
    );

    always #5 sys_clk = ~sys_clk;
    always begin #15; if (pri_on) ref_pri = ~ref_pri; end
    always begin #35; if (bak_on) ref_bak = ~ref_bak; end
    always @(posedge clk_out) out_edges++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural model of the selection, advanced once per system edge
    int m_state = 0;
    int m_cnt = 0;
    bit m_sel = 0;
    bit [2:0] m_req = '0;
    bit p_req = 0, p_auto = 1, p_bp = 0, p_bb = 0, p_rst = 0;

    always @(negedge sys_clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_sel = 0; m_req = '0;
        end else if (p_rst) begin
            bit rise, cur_bad, oth_bad;
            rise    = m_req[1] & ~m_req[2];
            cur_bad = m_sel ? p_bb : p_bp;
            oth_bad = m_sel ? p_bp : p_bb;
            case (m_state)
                0: if (!oth_bad && (rise || (p_auto && cur_bad))) begin
                       m_state = 1; m_cnt = 0;
                   end
                1: if (oth_bad) begin
                       m_state = 0; m_cnt = 0;
                   end else if (m_cnt == DLY - 1) begin
                       m_state = 2; m_cnt = 0; m_sel = ~m_sel;
                   end else m_cnt++;
                default: if (m_cnt == SETTLE - 1) begin
                       m_state = 0; m_cnt = 0;
                   end else m_cnt++;
            endcase
            m_req = {m_req[1:0], p_req};
        end
        if (rst_n)
            chk(active_sel === m_sel, "R4/R5/R8 per-cycle selection", int'(active_sel), int'(m_sel));
        p_req = switch_req; p_auto = auto_en; p_bp = bad_pri; p_bb = bad_bak; p_rst = rst_n;
    end

    task automatic step(input int n);
        repeat (n) @(posedge sys_clk);
        #2;
    endtask

    task automatic press();
        switch_req = 1'b1; step(3);
        switch_req = 1'b0; step(3);
    endtask

    task automatic out_follows(input int exp, input string req);
        out_edges = 0;
        step(100);
        chk(out_edges >= exp - 2 && out_edges <= exp + 2, req, out_edges, exp);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(3);
        chk(active_sel == 1'b0, "R1 reset selects primary", int'(active_sel), 0);
        chk(bad_pri == 1'b0 && bad_bak == 1'b0, "R1 flags clear before first window",
            int'({bad_pri, bad_bak}), 0);

        step(60);
        chk(bad_pri == 1'b0 && bad_bak == 1'b0, "R2 running references not flagged",
            int'({bad_pri, bad_bak}), 0);
        out_follows(33, "R9 output follows primary");

        press();
        step(SETTLE + 20);
        chk(active_sel == 1'b1, "R5 manual toggle to backup", int'(active_sel), 1);
        out_follows(14, "R9 output follows backup");

        press();
        step(60);
        chk(active_sel == 1'b0, "R5 manual toggle back to primary", int'(active_sel), 0);

        // second press lands while the first is still in DELAY
        switch_req = 1'b1; step(2); switch_req = 1'b0; step(2);
        switch_req = 1'b1; step(2); switch_req = 1'b0;
        step(60);
        chk(active_sel == 1'b1, "R8 press during delay ignored", int'(active_sel), 1);
        press();
        step(60);
        chk(active_sel == 1'b0, "R8 next press toggles again", int'(active_sel), 0);

        bak_on = 1'b0;
        step(60);
        chk(bad_bak == 1'b1, "R2 stopped backup flagged", int'(bad_bak), 1);
        chk(bad_pri == 1'b0, "R2 running primary not flagged", int'(bad_pri), 0);
        press();
        step(60);
        chk(active_sel == 1'b0, "R7 no manual move onto bad backup", int'(active_sel), 0);

        bak_on = 1'b1;
        step(WINDOW);
        chk(bad_bak == 1'b1, "R3 flag held after one window", int'(bad_bak), 1);
        step(64);
        chk(bad_bak == 1'b0, "R3 flag cleared after good windows", int'(bad_bak), 0);

        auto_en = 1'b0;
        pri_on = 1'b0;
        step(60);
        chk(bad_pri == 1'b1, "R6 stopped primary flagged", int'(bad_pri), 1);
        chk(active_sel == 1'b0, "R6 manual-only mode holds selection", int'(active_sel), 0);

        auto_en = 1'b1;
        step(SETTLE + DLY + 30);
        chk(active_sel == 1'b1, "R4 automatic failover to backup", int'(active_sel), 1);
        out_follows(14, "R10 handover away from stopped primary");

        bak_on = 1'b0;
        step(60);
        chk(bad_pri == 1'b1 && bad_bak == 1'b1, "R7 both flags reported",
            int'({bad_pri, bad_bak}), 3);
        chk(active_sel == 1'b1, "R7 selection held with both bad", int'(active_sel), 1);

        pri_on = 1'b1;
        step(160);
        chk(bad_pri == 1'b0, "R3 primary flag cleared", int'(bad_pri), 0);
        chk(active_sel == 1'b0, "R4 automatic failover back to primary", int'(active_sel), 0);
        out_follows(33, "R10 handover away from stopped backup");

        bak_on = 1'b1;
        step(80);
        chk(bad_bak == 1'b0, "R3 backup flag cleared", int'(bad_bak), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_fail);
        $finish;
    end
endmodule